// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block drives a reference clock out of the chip, derived from one of two sources: the system clock or the crystal clock. Both sources live in the block's single clock domain as one-cycle tick enables, one tick per source period. A write port loads one control word that holds an output enable, a keep-running-in-sleep flag, a source choice and a 4-bit divide code.

Code zero passes the chosen source through unchanged: one high cycle per tick. A code n between 1 and 15 divides the source by 2 to the power n, and the output has an even duty cycle. The divide code can only be loaded while the output is off. A write that reaches the code while the output is on keeps the old code but still updates the other fields. Switching the output off forces it low and clears the divider, so the next enable starts from a known phase. A sleep input silences the output and freezes the divider unless the keep-running flag is set.

Top module: `refclk_div`

## Requirements
- R1: After reset every control field is 0 (output off, keep flag clear, system source, code 0) and refOut is low.
- R2: A write with wrEn high loads the control word on the next rising edge. Its layout is: bit 0 output enable, bit 1 keep running in sleep, bit 2 source select, bits 6:3 divide code.
- R3: Source select 1 counts only xtalTick. Source select 0 counts only sysTick. Ticks of the other source have no effect on refOut.
- R4: A write made while the stored enable is 1 leaves the divide code unchanged. The other fields of that write still take effect.
- R5: With a code n from 1 to 15, refOut toggles after every 2^(n-1) counted ticks. This gives a period of 2^n ticks with 2^(n-1) ticks high. The first rising edge comes on the 2^(n-1)-th tick after enable.
- R6: With code 0, refOut is high for exactly one cycle following each counted tick and low otherwise.
- R7: While the stored enable is 0, refOut is low and the divider state is cleared. A write that clears the enable brings refOut low on the next cycle.
- R8: When sleepIn is high and the keep flag is 0, refOut goes low from the next cycle onward and ticks are not counted. When sleep ends, the divider resumes from its frozen phase.
- R9: When the keep flag is 1, sleepIn has no effect on refOut.
- R10: A counted tick changes refOut in the cycle after the tick, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysTick | input | 1 | One pulse per system clock period |
| xtalTick | input | 1 | One pulse per crystal clock period |
| sleepIn | input | 1 | Sleep request, high while the chip sleeps |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 7 | Control word, layout as in R2 |
| refOut | output | 1 | Divided reference clock |

## Verification
The inline properties check on every cycle four things: the divide code stays frozen while the output is on, a disabled divider is cleared, the count never passes its half-period limit, and the phase moves only on a counted tick. Further properties check that a disabling write or an unprotected sleep silences the output one cycle later. Whether each of the sixteen codes gives the right period and duty cycle, whether the output restarts from the right phase, and whether the ignored source truly has no effect can only be shown by the bench. It does this with a behavioural model compared every cycle and with measured periods.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

  // Control word field positions (fixed layout, see R2)
  localparam int EnBit   = 0;
  localparam int KeepBit = 1;
  localparam int SrcBit  = 2;
  localparam int CodeLsb = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;   // a counted source tick this cycle
    logic clr;   // output disabled: clear divider state
    logic mute;  // force the output low
    logic pass;  // code zero: undivided pass-through
  } refclk_strb_t;

endpackage

// File: rtl/refclk_ctrl.sv
module refclk_ctrl
  import refclk_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int REG_W = CODE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              sysTick,
  input  logic              xtalTick,
  input  logic              sleepIn,
  output refclk_strb_t      strb,
  output logic [CODE_W-1:0] codeOut
);

  logic              enQ;
  logic              keepQ;
  logic              xtalQ;
  logic              holdQ;
  logic [CODE_W-1:0] codeQ;
  logic              tickSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      keepQ <= 1'b0;
      xtalQ <= 1'b0;
      holdQ <= 1'b0;
      codeQ <= '0;
    end else begin
      holdQ <= sleepIn & ~keepQ;
      if (wrEn) begin
        enQ   <= wrData[EnBit];
        keepQ <= wrData[KeepBit];
        xtalQ <= wrData[SrcBit];
        if (!enQ) begin
          codeQ <= wrData[CodeLsb +: CODE_W];
        end
      end
    end
  end

  always_comb begin
    tickSel   = xtalQ ? xtalTick : sysTick;
    strb.run  = enQ & ~holdQ & tickSel;
    strb.clr  = ~enQ;
    strb.mute = holdQ | ~enQ;
    strb.pass = (codeQ == '0);
    codeOut   = codeQ;
  end

  // R4: the divide code cannot move while the output is on
  assert_code_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    enQ |=> $stable(codeQ));

  // R8: unprotected sleep stops tick counting from the next cycle
  assert_sleep_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sleepIn && !keepQ) |=> !strb.run);

endmodule

// File: rtl/refclk_dp.sv
module refclk_dp
  import refclk_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int CNT_W = (1 << CODE_W) - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  refclk_strb_t      strb,
  input  logic [CODE_W-1:0] codeIn,
  output logic              refOut
);

  logic [CNT_W-1:0] cntQ;
  logic             phaseQ;
  logic             passQ;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;

  // Half period minus one, in ticks: 2^(code-1) - 1
  always_comb begin
    span  = (CNT_W+1)'(1) << (codeIn - CODE_W'(1));
    limit = CNT_W'(span - (CNT_W+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      phaseQ <= 1'b0;
      passQ  <= 1'b0;
    end else if (strb.clr) begin
      cntQ   <= '0;
      phaseQ <= 1'b0;
      passQ  <= 1'b0;
    end else if (strb.pass) begin
      passQ <= strb.run;
    end else if (strb.run) begin
      if (cntQ == limit) begin
        cntQ   <= '0;
        phaseQ <= ~phaseQ;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  assign refOut = ~strb.mute & (strb.pass ? passQ : phaseQ);

  // R7: disabled divider is cleared on the following cycle
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cntQ == '0 && !phaseQ && !passQ));

  // R5: the count never exceeds its half-period limit
  assert_cnt_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pass |-> (cntQ <= limit));

  // R5: the phase only moves on a counted tick
  assert_phase_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clr && !strb.run) |=> $stable(phaseQ));

endmodule

// File: rtl/refclk_div.sv
module refclk_div
  import refclk_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int REG_W = CODE_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sysTick,
  input  logic             xtalTick,
  input  logic             sleepIn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic             refOut
);

  refclk_strb_t      strb;
  logic [CODE_W-1:0] code;

  refclk_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .sysTick  (sysTick),
    .xtalTick (xtalTick),
    .sleepIn  (sleepIn),
    .strb     (strb),
    .codeOut  (code)
  );

  refclk_dp #(.CODE_W(CODE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .codeIn (code),
    .refOut (refOut)
  );

  // R7: a write clearing the enable silences the output next cycle
  assert_disable_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[EnBit]) |=> !refOut);

endmodule

// File: tb/sim_refclk_div.sv
module sim_refclk_div;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sysTick = 1'b0;
  logic       xtalTick = 1'b0;
  logic       sleepIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [6:0] wrData = '0;
  logic       refOut;

  int nChecks = 0;
  int nFails  = 0;

  // Behavioural reference model state
  int mEn = 0, mKeep = 0, mSel = 0, mCode = 0;
  int mCnt = 0, mPhase = 0, mPass = 0, mHold = 0;

  always #5 clk = ~clk;

  refclk_div u0 (
    .clk(clk), .rstN(rstN), .sysTick(sysTick), .xtalTick(xtalTick),
    .sleepIn(sleepIn), .wrEn(wrEn), .wrData(wrData), .refOut(refOut)
  );

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s refOut=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model update on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mKeep = 0; mSel = 0; mCode = 0;
      mCnt = 0; mPhase = 0; mPass = 0; mHold = 0;
    end else begin
      int tick;
      int run;
      tick = mSel ? int'(xtalTick) : int'(sysTick);
      run  = (mEn != 0 && mHold == 0 && tick != 0) ? 1 : 0;
      if (mEn == 0) begin
        mCnt = 0; mPhase = 0; mPass = 0;
      end else if (mCode == 0) begin
        mPass = run;
      end else if (run != 0) begin
        if (mCnt == (1 << (mCode - 1)) - 1) begin
          mCnt = 0; mPhase = 1 - mPhase;
        end else begin
          mCnt++;
        end
      end
      mHold = (sleepIn && mKeep == 0) ? 1 : 0;
      if (wrEn) begin
        if (mEn == 0) mCode = int'(wrData[6:3]);
        mEn = int'(wrData[0]); mKeep = int'(wrData[1]); mSel = int'(wrData[2]);
      end
    end
  end

  // Cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic exp;
      string tag;
      exp = (mEn != 0 && mHold == 0) ? ((mCode == 0) ? mPass[0] : mPhase[0]) : 1'b0;
      if (mEn == 0) tag = "R7";
      else if (mHold != 0) tag = "R8";
      else if (mCode == 0) tag = "R6";
      else tag = "R5";
      check({tag, " model"}, refOut, exp);
    end
  end

  // Control word: bit0 enable, bit1 keep, bit2 source, bits 6:3 code (R2)
  function automatic logic [6:0] word(int en, int keep, int src, int code);
    return {4'(code), 1'(src), 1'(keep), 1'(en)};
  endfunction

  task automatic wr(logic [6:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // Observe two rising edges and one falling edge of refOut
  task automatic observe(int n, string req, int expFirst);
    int t = 0, r1 = -1, r2 = -1, f = -1;
    logic prev = refOut;
    while (r2 < 0 && t < 70000) begin
      @(negedge clk); t++;
      if (refOut && !prev) begin
        if (r1 < 0) r1 = t; else r2 = t;
      end
      if (!refOut && prev && r1 >= 0 && f < 0) f = t;
      prev = refOut;
    end
    checkInt({req, " period"}, r2 - r1, 1 << n);
    checkInt({req, " high time"}, f - r1, 1 << (n - 1));
    if (expFirst >= 0) checkInt({req, " first rise"}, r1, expFirst);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", refOut, 1'b0);
    rstN = 1'b1;
    sysTick = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", refOut, 1'b0);

    // R6 / R10: code 0 pass-through with sparse ticks
    sysTick = 1'b0;
    wr(word(1, 0, 0, 0));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sysTick = 1'b1;
      @(negedge clk); sysTick = 1'b0;
      check("R10 R6 high after tick", refOut, 1'b1);
      @(negedge clk);
      check("R6 low without tick", refOut, 1'b0);
    end

    // R3: crystal selected, only system ticks present
    wr(word(0, 0, 0, 0));
    wr(word(1, 0, 1, 1));
    sysTick = 1'b1; xtalTick = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R3 other source ignored", refOut, 1'b0);
    end
    xtalTick = 1'b1;
    observe(1, "R3 crystal code1", -1);
    xtalTick = 1'b0;

    // R4: code write while enabled is ignored, source change accepted
    wr(word(1, 0, 0, 5));
    observe(1, "R4 code kept", -1);

    // R5 / R2: every divide code, system source continuous
    for (int n = 1; n <= 15; n++) begin
      wr(word(0, 0, 0, 0));
      wr(word(1, 0, 0, n));
      observe(n, "R5 R2", 1 << (n - 1));
    end

    // R7: disable clears, re-enable restarts at known phase
    wr(word(0, 0, 0, 0));
    wr(word(1, 0, 0, 3));
    repeat (5) @(negedge clk);
    wr(word(0, 0, 0, 3));
    check("R7 low after disable", refOut, 1'b0);
    wr(word(1, 0, 0, 3));
    observe(3, "R7 restart", 4);

    // R8: sleep without keep flag
    wr(word(0, 0, 0, 0));
    wr(word(1, 0, 0, 2));
    repeat (3) @(negedge clk);
    sleepIn = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      check("R8 silent in sleep", refOut, 1'b0);
      @(negedge clk);
    end
    sleepIn = 1'b0;
    repeat (12) @(negedge clk);

    // R9: keep running in sleep
    wr(word(0, 0, 0, 0));
    wr(word(1, 1, 0, 1));
    sleepIn = 1'b1;
    begin
      int changes = 0;
      logic prev = refOut;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (refOut != prev) changes++;
        prev = refOut;
      end
      checkInt("R9 toggles in sleep", changes, 10);
    end
    sleepIn = 1'b0;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule